// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits inside a flash device model and watches the stream of bus write cycles. Each write carries an address and a word of data. The block recognises the multi-write command sequences that the device accepts. Every command begins with a two-write unlock prefix at fixed address and data pairs. After the prefix comes an opcode write, and for some commands more writes follow. When a sequence completes, the block emits a one-cycle command pulse. The pulse carries an operation code and the address and data of the final write. An execution engine outside the block consumes the pulse. The array, programming and erasing are not part of this block.

The block also keeps two pieces of state. The first is the read mode: normal array reads, or identification reads, in which a small offset selects the manufacturer or device code. The second is the state of a sector erase: idle, running or suspended. That state lets single-write suspend and resume requests take effect only when they make sense. Any write that breaks a sequence abandons it and returns reads to array mode.

Writes arrive on a valid/ready interface. The block never applies back-pressure: `wr_ready` stays high, so a write is accepted in every cycle where `wr_valid` is high. The command pulse, the read mode and the erase state are plain outputs with no handshake. The execution engine signals the end of an erase on `erase_done`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After a synchronous active-low reset, `cmd_valid` is 0, `id_mode` is 0, `erase_running` and `erase_held` are 0, and `wr_ready` is 1.
- R2: The unlock prefix is a write of data AAAA to address 00AAAA, then a write of data 5555 to address 005554. Bit 16 of the address is ignored when matching these command addresses and the AAAA opcode address.
- R3: The prefix followed by F0F0 at the opcode address gives a pulse with `cmd_op`=1 (reset/read), and `id_mode` becomes 0.
- R4: The prefix followed by 9090 at the opcode address gives `cmd_op`=2 and sets `id_mode`. While `id_mode` is 1, `id_rd_data` returns MFR_CODE for offset 00h, DEV_CODE for offset 02h, and 0 for any other offset. While `id_mode` is 0, `id_rd_data` is 0.
- R5: The prefix followed by A0A0 at the opcode address arms a program. The next write gives `cmd_op`=3, with `cmd_addr` and `cmd_data` equal to that write's full address (bit 16 included) and data. `id_mode` becomes 0.
- R6: The prefix, then 8080 at the opcode address, then the prefix again, then 1010 at the opcode address gives `cmd_op`=4 (segment erase).
- R7: The same six-write sequence ending in 3030 at any address gives `cmd_op`=5 (sector erase), with `cmd_addr` equal to that address, and `erase_running` becomes 1.
- R8: While an erase is running, a write whose low byte is B0, at any address, gives `cmd_op`=6 and moves the erase to suspended (`erase_held`=1). Every other write while running is ignored. While suspended, with no sequence in progress, a write whose low byte is 30 gives `cmd_op`=7 and resumes the erase. A pulse on `erase_done` while running returns the erase to idle.
- R9: Any write that does not match the next expected step abandons the sequence without a pulse and sets `id_mode` to 0.
- R10: With no sequence in progress, a low-byte B0 write when no erase is running, or a low-byte 30 write when no erase is suspended, is ignored: there is no pulse, and the read mode and erase state do not change.
- R11: `cmd_valid` is high for exactly the one cycle after the clock edge that accepts the completing write. `cmd_op`, `cmd_addr` and `cmd_data` are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Bus write present |
| wr_ready | output | 1 | Write accepted; always 1 |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| erase_done | input | 1 | Execution engine finished the running erase |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_op | output | 3 | Operation code, 1 to 7 as listed in the requirements |
| cmd_addr | output | ADDR_W | Address of the completing write |
| cmd_data | output | DATA_W | Data of the completing write |
| id_mode | output | 1 | 1 = identification reads, 0 = array reads |
| erase_running | output | 1 | Sector erase in progress |
| erase_held | output | 1 | Sector erase suspended |
| id_rd_addr | input | ID_OFS_W | Identification read offset |
| id_rd_data | output | DATA_W | Identification read data |

## Verification
The bench builds the block with its default parameters: a 24-bit address, 16-bit word data, bit 16 as the ignored address bit, and an 8-bit identification offset. With these values it can set bit 16 on unlock and opcode addresses and still expect a match. It can also place sector and program addresses far above the command window, and check that their bit 16 is kept in `cmd_addr`. Because the data width is two bytes, the bench can test suspend and resume writes whose upper byte is random. It can also check that a full-word 3030 is treated as the sector opcode in one state and as a resume or an ignored write in another.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_RESET     = 3'd1,
    OP_AUTOSEL   = 3'd2,
    OP_PROGRAM   = 3'd3,
    OP_SEG_ERASE = 3'd4,
    OP_SEC_ERASE = 3'd5,
    OP_SUSPEND   = 3'd6,
    OP_RESUME    = 3'd7
  } cmd_op_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PROG,
    SQ_ERS1,
    SQ_ERS2,
    SQ_ERS3
  } seq_state_e;

  typedef enum logic [1:0] {
    ER_IDLE,
    ER_RUN,
    ER_HELD
  } erase_state_e;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match #(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 16,
  parameter int SKIP_BIT = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              at_key_a,
  output logic              at_key_b,
  output logic              d_unl1,
  output logic              d_unl2,
  output logic              d_reset,
  output logic              d_ident,
  output logic              d_prog,
  output logic              d_erase,
  output logic              d_seg,
  output logic              d_sec,
  output logic              d_susp,
  output logic              d_resume
);
  localparam int NBYTES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] KEEP  = ~(ADDR_W'(1) << SKIP_BIT);
  localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(32'h0000_AAAA);
  localparam logic [ADDR_W-1:0] KEY_B = ADDR_W'(32'h0000_5554);

  function automatic logic [DATA_W-1:0] rep(input logic [7:0] b);
    return {NBYTES{b}};
  endfunction

  assign at_key_a = (addr & KEEP) == KEY_A;
  assign at_key_b = (addr & KEEP) == KEY_B;
  assign d_unl1   = data == rep(8'hAA);
  assign d_unl2   = data == rep(8'h55);
  assign d_reset  = data == rep(8'hF0);
  assign d_ident  = data == rep(8'h90);
  assign d_prog   = data == rep(8'hA0);
  assign d_erase  = data == rep(8'h80);
  assign d_seg    = data == rep(8'h10);
  assign d_sec    = data == rep(8'h30);
  assign d_susp   = data[7:0] == 8'hB0;
  assign d_resume = data[7:0] == 8'h30;
endmodule

// File: rtl/flash_erase_track.sv
module flash_erase_track
  import flash_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic susp_req,
  input  logic resume_req,
  input  logic done,
  output logic run_now,
  output logic running,
  output logic held
);
  erase_state_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ER_IDLE;
    end else if (start) begin
      st_q <= ER_RUN;
    end else begin
      unique case (st_q)
        ER_RUN:  if (done) st_q <= ER_IDLE;
                 else if (susp_req) st_q <= ER_HELD;
        ER_HELD: if (resume_req) st_q <= ER_RUN;
        default: st_q <= st_q;
      endcase
    end
  end

  assign running = st_q == ER_RUN;
  assign held    = st_q == ER_HELD;
  assign run_now = running && !done;

  // R8: the suspended state is only reached from a running erase
  p_held_from_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !$past(held)) |-> $past(running));
  // R8: leaving suspension needs a resume request or a new start
  p_resume_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(held) && running) |-> ($past(resume_req) || $past(start)));
  p_state_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({running, held}));
endmodule

// File: rtl/flash_id_read.sv
module flash_id_read #(
  parameter int              DATA_W   = 16,
  parameter int              ID_OFS_W = 8,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h0101,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'hA4A4
) (
  input  logic                id_mode,
  input  logic [ID_OFS_W-1:0] ofs,
  output logic [DATA_W-1:0]   rd_data
);
  localparam logic [ID_OFS_W-1:0] OFS_MFR = ID_OFS_W'(0);
  localparam logic [ID_OFS_W-1:0] OFS_DEV = ID_OFS_W'(2);

  always_comb begin
    rd_data = '0;
    if (id_mode) begin
      if (ofs == OFS_MFR)      rd_data = MFR_CODE;
      else if (ofs == OFS_DEV) rd_data = DEV_CODE;
    end
  end

  // R4: identification data never appears in array mode
  always_comb begin
    if (!id_mode) p_quiet_in_array_r4: assert (rd_data == '0);
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int              ADDR_W   = 24,
  parameter int              DATA_W   = 16,
  parameter int              SKIP_BIT = 16,
  parameter int              ID_OFS_W = 8,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h0101,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'hA4A4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                erase_done,
  output logic                cmd_valid,
  output logic [2:0]          cmd_op,
  output logic [ADDR_W-1:0]   cmd_addr,
  output logic [DATA_W-1:0]   cmd_data,
  output logic                id_mode,
  output logic                erase_running,
  output logic                erase_held,
  input  logic [ID_OFS_W-1:0] id_rd_addr,
  output logic [DATA_W-1:0]   id_rd_data
);
  logic at_a, at_b, d_unl1, d_unl2, d_reset, d_ident, d_prog, d_erase;
  logic d_seg, d_sec, d_susp, d_resume;
  logic ers_run_now;

  flash_cmd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SKIP_BIT(SKIP_BIT)) u_match (
    .addr(wr_addr), .data(wr_data),
    .at_key_a(at_a), .at_key_b(at_b),
    .d_unl1(d_unl1), .d_unl2(d_unl2), .d_reset(d_reset), .d_ident(d_ident),
    .d_prog(d_prog), .d_erase(d_erase), .d_seg(d_seg), .d_sec(d_sec),
    .d_susp(d_susp), .d_resume(d_resume)
  );

  seq_state_e seq_q, seq_nxt;
  logic       id_q, id_nxt;
  logic       fire, go_sec, go_susp, go_res;
  cmd_op_e    op_nxt, op_q;
  logic       valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    seq_nxt = seq_q;
    id_nxt  = id_q;
    fire    = 1'b0;
    op_nxt  = OP_NONE;
    go_sec  = 1'b0;
    go_susp = 1'b0;
    go_res  = 1'b0;
    if (wr_valid) begin
      if (ers_run_now) begin
        if (d_susp) begin
          fire = 1'b1; op_nxt = OP_SUSPEND; go_susp = 1'b1;
        end
      end else if (seq_q == SQ_IDLE && d_resume && erase_held) begin
        fire = 1'b1; op_nxt = OP_RESUME; go_res = 1'b1;
      end else if (seq_q == SQ_IDLE && (d_susp || d_resume)) begin
        seq_nxt = SQ_IDLE;
      end else begin
        seq_nxt = SQ_IDLE;
        unique case (seq_q)
          SQ_IDLE: if (at_a && d_unl1) seq_nxt = SQ_UNL1; else id_nxt = 1'b0;
          SQ_UNL1: if (at_b && d_unl2) seq_nxt = SQ_UNL2; else id_nxt = 1'b0;
          SQ_UNL2: begin
            if (at_a && d_reset) begin
              fire = 1'b1; op_nxt = OP_RESET; id_nxt = 1'b0;
            end else if (at_a && d_ident) begin
              fire = 1'b1; op_nxt = OP_AUTOSEL; id_nxt = 1'b1;
            end else if (at_a && d_prog) begin
              seq_nxt = SQ_PROG;
            end else if (at_a && d_erase) begin
              seq_nxt = SQ_ERS1;
            end else begin
              id_nxt = 1'b0;
            end
          end
          SQ_PROG: begin
            fire = 1'b1; op_nxt = OP_PROGRAM; id_nxt = 1'b0;
          end
          SQ_ERS1: if (at_a && d_unl1) seq_nxt = SQ_ERS2; else id_nxt = 1'b0;
          SQ_ERS2: if (at_b && d_unl2) seq_nxt = SQ_ERS3; else id_nxt = 1'b0;
          SQ_ERS3: begin
            id_nxt = 1'b0;
            if (at_a && d_seg) begin
              fire = 1'b1; op_nxt = OP_SEG_ERASE;
            end else if (d_sec) begin
              fire = 1'b1; op_nxt = OP_SEC_ERASE; go_sec = 1'b1;
            end
          end
          default: id_nxt = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q   <= SQ_IDLE;
      id_q    <= 1'b0;
      valid_q <= 1'b0;
      op_q    <= OP_NONE;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      seq_q   <= seq_nxt;
      id_q    <= id_nxt;
      valid_q <= fire;
      if (fire) begin
        op_q   <= op_nxt;
        addr_q <= wr_addr;
        data_q <= wr_data;
      end
    end
  end

  flash_erase_track u_erase (
    .clk(clk), .rst_n(rst_n), .start(go_sec), .susp_req(go_susp),
    .resume_req(go_res), .done(erase_done), .run_now(ers_run_now),
    .running(erase_running), .held(erase_held)
  );

  flash_id_read #(.DATA_W(DATA_W), .ID_OFS_W(ID_OFS_W),
                  .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .id_mode(id_q), .ofs(id_rd_addr), .rd_data(id_rd_data)
  );

  assign wr_ready  = 1'b1;
  assign cmd_valid = valid_q;
  assign cmd_op    = op_q;
  assign cmd_addr  = addr_q;
  assign cmd_data  = data_q;
  assign id_mode   = id_q;

  // R11: a pulse only follows an accepted write
  p_pulse_after_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(wr_valid));
  // R4: identification mode is entered only with an autoselect pulse
  p_ident_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> (cmd_valid && cmd_op == OP_AUTOSEL));
  // R5: a program pulse leaves array mode selected
  p_prog_leaves_ident_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PROGRAM) |-> !id_mode);
  // R7: a sector erase pulse coincides with a running erase
  p_sec_starts_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SEC_ERASE) |-> erase_running);
  // R8: a suspend pulse coincides with the suspended state
  p_susp_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SUSPEND) |-> erase_held);
endmodule

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [23:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        erase_done = 1'b0;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [23:0] cmd_addr;
  logic [15:0] cmd_data;
  logic        id_mode, erase_running, erase_held;
  logic [7:0]  id_rd_addr = '0;
  logic [15:0] id_rd_data;

  always #2 clk = ~clk;

  flash_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .erase_done(erase_done),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .id_mode(id_mode), .erase_running(erase_running), .erase_held(erase_held),
    .id_rd_addr(id_rd_addr), .id_rd_data(id_rd_data)
  );

  int vectors = 0;
  int fails = 0;

  // reference state
  int          ms = 0;
  logic        mid = 0;
  int          mers = 0;
  logic        ev = 0;
  logic [2:0]  eop = 0;
  logic [23:0] eaddr = 0;
  logic [15:0] edata = 0;

  function automatic logic is_a(logic [23:0] a);
    return (a & 24'hFE_FFFF) == 24'h00_AAAA;
  endfunction
  function automatic logic is_b(logic [23:0] a);
    return (a & 24'hFE_FFFF) == 24'h00_5554;
  endfunction
  function automatic logic [15:0] exp_id(logic m, logic [7:0] o);
    if (!m) return 16'h0;
    if (o == 8'h00) return 16'h0101;
    if (o == 8'h02) return 16'hA4A4;
    return 16'h0;
  endfunction

  task automatic emit(logic [2:0] op, logic [23:0] a, logic [15:0] d);
    ev = 1; eop = op; eaddr = a; edata = d;
  endtask

  task automatic model(logic [23:0] a, logic [15:0] d);
    ev = 0;
    if (mers == 1) begin
      if (d[7:0] == 8'hB0) begin emit(3'd6, a, d); mers = 2; end
    end else if (ms == 0 && mers == 2 && d[7:0] == 8'h30) begin
      emit(3'd7, a, d); mers = 1;
    end else if (ms == 0 && (d[7:0] == 8'hB0 || d[7:0] == 8'h30)) begin
      // ignored
    end else begin
      case (ms)
        0: if (is_a(a) && d == 16'hAAAA) ms = 1; else mid = 0;
        1: if (is_b(a) && d == 16'h5555) ms = 2; else begin ms = 0; mid = 0; end
        2: begin
          ms = 0;
          if (is_a(a) && d == 16'hF0F0) begin emit(3'd1, a, d); mid = 0; end
          else if (is_a(a) && d == 16'h9090) begin emit(3'd2, a, d); mid = 1; end
          else if (is_a(a) && d == 16'hA0A0) ms = 3;
          else if (is_a(a) && d == 16'h8080) ms = 4;
          else mid = 0;
        end
        3: begin emit(3'd3, a, d); mid = 0; ms = 0; end
        4: if (is_a(a) && d == 16'hAAAA) ms = 5; else begin ms = 0; mid = 0; end
        5: if (is_b(a) && d == 16'h5555) ms = 6; else begin ms = 0; mid = 0; end
        default: begin
          ms = 0; mid = 0;
          if (is_a(a) && d == 16'h1010) emit(3'd4, a, d);
          else if (d == 16'h3030) begin emit(3'd5, a, d); mers = 1; end
        end
      endcase
    end
  endtask

  task automatic compare(string tag);
    logic bad;
    vectors++;
    bad = (cmd_valid !== ev) || (id_mode !== mid) ||
          (erase_running !== (mers == 1)) || (erase_held !== (mers == 2)) ||
          (ev && (cmd_op !== eop || cmd_addr !== eaddr || cmd_data !== edata));
    if (bad) begin
      fails++;
      $display("FAIL %s: got v=%0b op=%0d a=%h d=%h id=%0b run=%0b held=%0b exp v=%0b op=%0d a=%h d=%h id=%0b run=%0b held=%0b",
               tag, cmd_valid, cmd_op, cmd_addr, cmd_data, id_mode, erase_running, erase_held,
               ev, eop, eaddr, edata, mid, mers == 1, mers == 2);
    end
  endtask

  task automatic wr(logic [23:0] a, logic [15:0] d, string tag);
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data = d;
    model(a, d);
    @(negedge clk);
    wr_valid = 0;
    compare(tag);
  endtask

  task automatic done_pulse(string tag);
    @(negedge clk);
    erase_done = 1;
    ev = 0;
    if (mers == 1) mers = 0;
    @(negedge clk);
    erase_done = 0;
    compare(tag);
  endtask

  task automatic id_check(logic [7:0] o, string tag);
    @(negedge clk);
    id_rd_addr = o;
    #1;
    vectors++;
    if (id_rd_data !== exp_id(mid, o)) begin
      fails++;
      $display("FAIL %s: id ofs %h got %h exp %h", tag, o, id_rd_data, exp_id(mid, o));
    end
  endtask

  task automatic unlock(string tag, logic b16 = 0);
    wr({7'd0, b16, 16'hAAAA}, 16'hAAAA, tag);
    wr({7'd0, b16, 16'h5554}, 16'h5555, tag);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got hang exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    vectors++;
    if (cmd_valid !== 0 || id_mode !== 0 || erase_running !== 0 || erase_held !== 0 || wr_ready !== 1) begin
      fails++;
      $display("FAIL R1: got v=%0b id=%0b run=%0b held=%0b rdy=%0b exp 0 0 0 0 1",
               cmd_valid, id_mode, erase_running, erase_held, wr_ready);
    end

    // R2, R4: autoselect with bit 16 set on the command addresses
    unlock("R2", 1);
    wr(24'h01AAAA, 16'h9090, "R4");
    id_check(8'h00, "R4");
    id_check(8'h02, "R4");
    id_check(8'h04, "R4");
    // R10: suspend byte with no erase leaves id mode
    wr(24'h123456, 16'h77B0, "R10");
    wr(24'h000000, 16'h3030, "R10");
    // R3 reset
    unlock("R3");
    wr(24'h00AAAA, 16'hF0F0, "R3");
    id_check(8'h00, "R4");
    // R5 program, address bit 16 kept
    unlock("R5");
    wr(24'h00AAAA, 16'hA0A0, "R5");
    wr(24'h71_2345, 16'h5A3C, "R5");
    // R11: pulse lasts one cycle
    @(negedge clk);
    vectors++;
    if (cmd_valid !== 0) begin
      fails++;
      $display("FAIL R11: got cmd_valid=%0b exp 0", cmd_valid);
    end
    // R6 segment erase
    unlock("R6"); wr(24'h00AAAA, 16'h8080, "R6");
    unlock("R6"); wr(24'h00AAAA, 16'h1010, "R6");
    // R7 sector erase
    unlock("R7"); wr(24'h00AAAA, 16'h8080, "R7");
    unlock("R7"); wr(24'h35_0000, 16'h3030, "R7");
    // R8: other writes ignored while running, then suspend/resume
    wr(24'h00AAAA, 16'hAAAA, "R8");
    wr(24'h000010, 16'hC3B0, "R8");
    unlock("R8"); wr(24'h00AAAA, 16'h9090, "R8");
    id_check(8'h02, "R4");
    wr(24'h000010, 16'h0030, "R8");
    done_pulse("R8");
    // R10: resume while idle ignored
    wr(24'h000020, 16'h0030, "R10");
    // R9: malformed sequences abort
    unlock("R9"); wr(24'h00AAAA, 16'h9090, "R9");
    wr(24'h00AAAA, 16'hAAAA, "R9");
    wr(24'h005554, 16'h1234, "R9");
    unlock("R9"); wr(24'h00AAAA, 16'h9090, "R9");
    unlock("R9"); wr(24'h00AAAA, 16'h8080, "R9");
    unlock("R9"); wr(24'h00AAAB, 16'h1010, "R9");

    // constrained random mix
    for (int it = 0; it < 1500; it++) begin
      int kind;
      int n;
      logic [23:0] sa [6];
      logic [15:0] sd [6];
      kind = $urandom_range(0, 9);
      n = 0;
      if (kind <= 4) begin
        sa[0] = 24'h00AAAA; sd[0] = 16'hAAAA;
        sa[1] = 24'h005554; sd[1] = 16'h5555;
        sa[2] = 24'h00AAAA;
        n = 3;
        case (kind)
          0: sd[2] = 16'hF0F0;
          1: sd[2] = 16'h9090;
          2: begin sd[2] = 16'hA0A0; sa[3] = 24'($urandom); sd[3] = 16'($urandom); n = 4; end
          default: begin
            sd[2] = 16'h8080;
            sa[3] = 24'h00AAAA; sd[3] = 16'hAAAA;
            sa[4] = 24'h005554; sd[4] = 16'h5555;
            if (kind == 3) begin sa[5] = 24'h00AAAA; sd[5] = 16'h1010; end
            else begin sa[5] = 24'($urandom); sd[5] = 16'h3030; end
            n = 6;
          end
        endcase
        for (int k = 0; k < n; k++)
          if (sa[k][15:0] == 16'hAAAA || sa[k][15:0] == 16'h5554)
            sa[k][16] = 1'($urandom_range(0, 1));
        if ($urandom_range(0, 7) == 0) begin
          int c = $urandom_range(0, n - 1);
          if ($urandom_range(0, 1) == 1) sd[c] = 16'($urandom);
          else sa[c] = 24'($urandom);
        end
        for (int k = 0; k < n; k++) wr(sa[k], sd[k], "RND");
      end else if (kind == 5) begin
        wr(24'($urandom), {8'($urandom), 8'hB0}, "RND");
      end else if (kind == 6) begin
        wr(24'($urandom), {8'($urandom), 8'h30}, "RND");
      end else if (kind == 7) begin
        done_pulse("RND");
      end else if (kind == 8) begin
        wr(24'($urandom), 16'($urandom), "RND");
      end else begin
        id_check(8'($urandom_range(0, 3)), "RND");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule